// File: doc/BRIEF.md
# Power-Fail Write-Protect Supervisor

This block guards a battery-backed static memory while its main supply comes and goes. It runs on an always-on clock and reads two digital comparator flags. The first flag says the supply is above the write-protect trip level. The second says the supply is above a lower level at which the memory may still run from the main rail. From these flags it does four things:

- It isolates the memory by forcing its chip-enable, write-enable and output-enable strobes inactive.
- It selects the backup cell as the memory's power source when the supply falls below the lower level.
- It drives the sink enable of an open-drain, active-low processor reset.
- It keeps a one-time latch that connects the backup cell the first time the supply becomes valid.

On power-up, isolation and reset are both held for a while after the supply is valid again. The counters for these holds are derived from a clock-frequency parameter. Isolation ends after a recovery window. Reset is released after a longer hold. A `recov_done` flag lets neighbouring blocks start their own activity once recovery has ended. Both comparator flags are synchronized inside the block. Timing constants are given in microseconds, so a bench can scale them down.

Top module: `pfs_supervisor`

## Requirements
- R1: While `arst_n` is low, the block is in its backup state. `mem_iso`=1, `rst_sink`=1, `recov_done`=0, `bkup_armed`=0 and `bkup_sel`=0, and all three memory strobes are 1.
- R2: When `vtp_ok_raw` falls, `mem_iso` becomes 1 at the third rising clock edge after the change (two synchronizer stages plus one state register). From then on, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are forced to 1 whatever the host strobes are.
- R3: `rst_sink` (1 means the reset pin is pulled low) becomes 1 on the same edge as R2's protection. The port only ever enables a pull-down; it is never a high drive.
- R4: While armed, `bkup_sel` becomes 1 at the third edge after `vsw_ok_raw` falls, and returns to 0 at the third edge after it rises.
- R5: After `vtp_ok_raw` rises, with `vsw_ok_raw` high, `mem_iso` falls and `recov_done` rises exactly at edge 2+REC_CYC. Here REC_CYC = (CLK_HZ/1e6)*REC_US.
- R6: `rst_sink` falls exactly at edge 2+RST_CYC after that rise, where RST_CYC = (CLK_HZ/1e6)*RST_US and RST_CYC > REC_CYC. Reset is never released while the memory is still isolated.
- R7: `bkup_armed` is set at the third edge after `vtp_ok_raw` first rises, and then stays set through every later supply loss. While it is 0, `bkup_sel` stays 0.
- R8: A drop of the synchronized supply-valid flag during the power-up hold restarts both the recovery and the reset counts from zero.
- R9: When `mem_iso` is 0, `mem_ce_n`, `mem_we_n` and `mem_oe_n` equal `host_ce_n`, `host_we_n` and `host_oe_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on supervisor clock |
| arst_n | input | 1 | Asynchronous power-on clear of the supervisor, active low |
| vtp_ok_raw | input | 1 | Comparator flag: supply above the write-protect trip level |
| vsw_ok_raw | input | 1 | Comparator flag: supply above the backup switchover level |
| host_ce_n | input | 1 | Host chip-enable, active low |
| host_we_n | input | 1 | Host write-enable, active low |
| host_oe_n | input | 1 | Host output-enable, active low |
| mem_ce_n | output | 1 | Gated chip-enable to the memory |
| mem_we_n | output | 1 | Gated write-enable to the memory |
| mem_oe_n | output | 1 | Gated output-enable to the memory; held high to float the data outputs |
| mem_iso | output | 1 | Write-protect / isolate indication |
| bkup_sel | output | 1 | Select the backup cell as the memory supply |
| bkup_armed | output | 1 | One-time backup-cell enable latch |
| rst_sink | output | 1 | Pull-down enable of the open-drain processor reset |
| recov_done | output | 1 | Recovery window finished; the memory is accessible |

## Verification
Two events can land on the same clock edge: the end of the recovery window and a fresh loss of the synchronized supply flag. The bench provokes this by dropping `vtp_ok_raw` so that the synchronized flag goes low just before the edge on which recovery would complete. It then requires that `mem_iso` stays 1 and that `recov_done` never shows even a one-cycle pulse. The per-edge sweeps around power-up, glitch restart and power-down compare every output against edge counts worked out from the synchronizer depth and the parameters.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
   typedef enum logic [1:0] {
      PFS_BACKUP    = 2'd0,
      PFS_PROTECTED = 2'd1,
      PFS_POWER_OK  = 2'd2
   } pfs_state_e;
endpackage

// File: rtl/pfs_sync.sv
module pfs_sync #(
   parameter int STAGES = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic arst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad
         $error("pfs_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge arst_n) begin
               if (!arst_n) chain[0] <= RST_VAL;
               else         chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge arst_n) begin
               if (!arst_n) chain[i] <= RST_VAL;
               else         chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pfs_hold_timer.sv
module pfs_hold_timer #(
   parameter int REC_CYC = 20,
   parameter int RST_CYC = 32,
   localparam int CNT_W = $clog2(RST_CYC + 1)
) (
   input  logic clk,
   input  logic arst_n,
   input  logic run,
   output logic rec_reach,
   output logic rst_reach
);
   localparam logic [CNT_W-1:0] REC_LIM = CNT_W'(REC_CYC);
   localparam logic [CNT_W-1:0] RST_LIM = CNT_W'(RST_CYC);

   logic [CNT_W-1:0] cnt_q, cnt_d;

   always_comb begin
      if (!run)                 cnt_d = '0;
      else if (cnt_q == RST_LIM) cnt_d = cnt_q;
      else                      cnt_d = cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) cnt_q <= '0;
      else         cnt_q <= cnt_d;
   end

   // next-state view so the sequencer registers on the same edge
   assign rec_reach = (cnt_d >= REC_LIM);
   assign rst_reach = (cnt_d >= RST_LIM);

   // R8
   cnt_clear_chk: assert property (@(posedge clk) disable iff (!arst_n)
      !run |=> (cnt_q == '0));
   // R8
   cnt_step_chk: assert property (@(posedge clk) disable iff (!arst_n)
      (run && cnt_q != RST_LIM) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/pfs_seq.sv
module pfs_seq
   import pfs_pkg::*;
(
   input  logic clk,
   input  logic arst_n,
   input  logic vtp_s,
   input  logic vsw_s,
   input  logic rec_reach,
   input  logic rst_reach,
   output logic iso,
   output logic sink,
   output logic armed,
   output logic sel,
   output logic done
);
   pfs_state_e state_q, state_d;
   logic       sink_q, sink_d;
   logic       armed_q;

   always_comb begin
      if (!vsw_s)         state_d = PFS_BACKUP;
      else if (!vtp_s)    state_d = PFS_PROTECTED;
      else if (rec_reach) state_d = PFS_POWER_OK;
      else                state_d = PFS_PROTECTED;
      sink_d = !(vtp_s && rst_reach);
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         state_q <= PFS_BACKUP;
         sink_q  <= 1'b1;
         armed_q <= 1'b0;
      end else begin
         state_q <= state_d;
         sink_q  <= sink_d;
         armed_q <= armed_q | vtp_s;
      end
   end

   assign iso   = (state_q != PFS_POWER_OK);
   assign done  = (state_q == PFS_POWER_OK);
   assign sink  = sink_q;
   assign armed = armed_q;
   assign sel   = (state_q == PFS_BACKUP) && armed_q;

   // R2
   wp_on_loss_chk: assert property (@(posedge clk) disable iff (!arst_n)
      !vtp_s |=> iso);
   // R3
   rst_on_loss_chk: assert property (@(posedge clk) disable iff (!arst_n)
      !vtp_s |=> sink);
   // R6
   rst_after_rec_chk: assert property (@(posedge clk) disable iff (!arst_n)
      !sink |-> done);
   // R7
   armed_sticky_chk: assert property (@(posedge clk) disable iff (!arst_n)
      armed |=> armed);
   // R7
   sel_needs_arm_chk: assert property (@(posedge clk) disable iff (!arst_n)
      sel |-> armed);
   // R4
   sel_on_low_chk: assert property (@(posedge clk) disable iff (!arst_n)
      (!vsw_s && armed) |=> sel);
endmodule

// File: rtl/pfs_supervisor.sv
module pfs_supervisor #(
   parameter int CLK_HZ      = 50_000_000,
   parameter int REC_US      = 150_000,
   parameter int RST_US      = 200_000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   input  logic vtp_ok_raw,
   input  logic vsw_ok_raw,
   input  logic host_ce_n,
   input  logic host_we_n,
   input  logic host_oe_n,
   output logic mem_ce_n,
   output logic mem_we_n,
   output logic mem_oe_n,
   output logic mem_iso,
   output logic bkup_sel,
   output logic bkup_armed,
   output logic rst_sink,
   output logic recov_done
);
   localparam int CYC_PER_US = CLK_HZ / 1_000_000;
   localparam int REC_CYC    = CYC_PER_US * REC_US;
   localparam int RST_CYC    = CYC_PER_US * RST_US;

   generate
      if (CYC_PER_US < 1) begin : g_chk_clk
         $error("pfs_supervisor: CLK_HZ must be at least 1 MHz");
      end
      if (REC_US < 1 || RST_US <= REC_US) begin : g_chk_order
         $error("pfs_supervisor: need 0 < REC_US < RST_US");
      end
   endgenerate

   logic vtp_s, vsw_s, rec_reach, rst_reach;

   pfs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_vtp (
      .clk(clk), .arst_n(arst_n), .d(vtp_ok_raw), .q(vtp_s));

   pfs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_vsw (
      .clk(clk), .arst_n(arst_n), .d(vsw_ok_raw), .q(vsw_s));

   pfs_hold_timer #(.REC_CYC(REC_CYC), .RST_CYC(RST_CYC)) u_timer (
      .clk(clk), .arst_n(arst_n), .run(vtp_s),
      .rec_reach(rec_reach), .rst_reach(rst_reach));

   pfs_seq u_seq (
      .clk(clk), .arst_n(arst_n), .vtp_s(vtp_s), .vsw_s(vsw_s),
      .rec_reach(rec_reach), .rst_reach(rst_reach),
      .iso(mem_iso), .sink(rst_sink), .armed(bkup_armed),
      .sel(bkup_sel), .done(recov_done));

   assign mem_ce_n = host_ce_n | mem_iso;
   assign mem_we_n = host_we_n | mem_iso;
   assign mem_oe_n = host_oe_n | mem_iso;

   // R9
   pass_thru_chk: assert property (@(posedge clk) disable iff (!arst_n)
      recov_done |-> (mem_we_n == host_we_n && mem_ce_n == host_ce_n));
   // R2
   strobe_block_chk: assert property (@(posedge clk) disable iff (!arst_n)
      !recov_done |-> (mem_we_n && mem_ce_n && mem_oe_n));
endmodule

// File: tb/tb_pfs_supervisor.sv
module tb_pfs_supervisor;
   localparam int REC = 20;
   localparam int RST = 32;

   logic clk = 1'b0;
   logic arst_n = 1'b0;
   logic vtp = 1'b0, vsw = 1'b0;
   logic hce = 1'b0, hwe = 1'b0, hoe = 1'b0;
   logic mce, mwe, moe, iso, sel, armed, sink, done;
   int checks = 0, fails = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   pfs_supervisor #(.CLK_HZ(1_000_000), .REC_US(REC), .RST_US(RST)) dut (
      .clk(clk), .arst_n(arst_n), .vtp_ok_raw(vtp), .vsw_ok_raw(vsw),
      .host_ce_n(hce), .host_we_n(hwe), .host_oe_n(hoe),
      .mem_ce_n(mce), .mem_we_n(mwe), .mem_oe_n(moe), .mem_iso(iso),
      .bkup_sel(sel), .bkup_armed(armed), .rst_sink(sink), .recov_done(done));

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%b exp=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic edge_wait();
      @(posedge clk); #5;
   endtask

   // power-up sweep from a rising vtp driven at a negedge
   task automatic powerup_sweep(input bit check_arm);
      for (int i = 1; i <= RST + 4; i++) begin
         edge_wait();
         chk("R5 iso", iso, (i < 2 + REC));
         chk("R5 done", done, (i >= 2 + REC));
         chk("R6 rst_sink", sink, (i < 2 + RST));
         if (check_arm) chk("R7 armed", armed, (i >= 3));
      end
   endtask

   initial begin
      #100000000;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      // R1 reset state
      #35;
      chk("R1 iso", iso, 1'b1);
      chk("R1 rst_sink", sink, 1'b1);
      chk("R1 done", done, 1'b0);
      chk("R1 armed", armed, 1'b0);
      chk("R1 sel", sel, 1'b0);
      chk("R1 we", mwe, 1'b1);
      chk("R1 ce", mce, 1'b1);
      chk("R1 oe", moe, 1'b1);
      @(negedge clk); arst_n = 1'b1;
      repeat (5) edge_wait();
      // R7 not armed yet: backup never selected
      chk("R7 sel unarmed", sel, 1'b0);

      // switchover level restored, trip level not yet
      @(negedge clk); vsw = 1'b1;
      repeat (4) edge_wait();
      chk("R7 sel unarmed prot", sel, 1'b0);
      chk("R2 iso prot", iso, 1'b1);

      // first power-up
      @(negedge clk); vtp = 1'b1;
      powerup_sweep(1'b1);

      // R9 pass-through, all strobe patterns
      for (int p = 0; p < 8; p++) begin
         @(negedge clk); {hce, hwe, hoe} = 3'(p);
         #2;
         chk("R9 ce", mce, hce);
         chk("R9 we", mwe, hwe);
         chk("R9 oe", moe, hoe);
      end

      // R2/R3 power loss, host actively writing
      @(negedge clk); {hce, hwe, hoe} = 3'b000; vtp = 1'b0;
      for (int i = 1; i <= 5; i++) begin
         edge_wait();
         chk("R2 iso", iso, (i >= 3));
         chk("R2 we", mwe, (i >= 3));
         chk("R2 ce", mce, (i >= 3));
         chk("R2 oe", moe, (i >= 3));
         chk("R3 rst_sink", sink, (i >= 3));
      end

      // R4 drop below switchover
      @(negedge clk); vsw = 1'b0;
      for (int i = 1; i <= 5; i++) begin
         edge_wait();
         chk("R4 sel on", sel, (i >= 3));
         chk("R7 armed kept", armed, 1'b1);
      end
      @(negedge clk); vsw = 1'b1;
      for (int i = 1; i <= 5; i++) begin
         edge_wait();
         chk("R4 sel off", sel, (i < 3));
      end

      // R8 glitch restart during the hold
      @(negedge clk); vtp = 1'b1;
      repeat (10) edge_wait();
      @(negedge clk); vtp = 1'b0;
      edge_wait();
      @(negedge clk); vtp = 1'b1;
      powerup_sweep(1'b0);
      chk("R8 done after restart", done, 1'b1);

      // collision: supply loss lands on the recovery-completion edge
      @(negedge clk); vtp = 1'b0;
      repeat (6) edge_wait();
      @(negedge clk); vtp = 1'b1;
      repeat (REC - 1) edge_wait();
      @(negedge clk); vtp = 1'b0;
      for (int i = 1; i <= 8; i++) begin
         edge_wait();
         chk("R5 collision done", done, 1'b0);
         chk("R2 collision iso", iso, 1'b1);
         chk("R6 collision rst", sink, 1'b1);
      end

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule